// File: doc/BRIEF.md
# BCD Calendar Clock with Frozen Host View

This block keeps a running calendar count in packed BCD: seconds, minutes, hours (24-hour), day of week, day of month, month, year and century. Each one-cycle pulse on the seconds input advances the count by one second. Carries ripple through the fields, month lengths are honoured, and February has 29 days in every year whose two-digit year is a multiple of four.

The host reaches the block through a byte-wide register bus. Writes are synchronous and reads are combinational. The host never reads the running counter directly. It reads a holding copy. While the transfer-enable bit in the control register is set, the holding copy tracks the running counter one clock behind. When the host clears the bit, the holding copy freezes so that all fields can be read as one coherent set, and the running counter keeps counting underneath. Time-field writes made while frozen land in the holding copy. When the bit is set again they are loaded into the running counter together, as one set. If nothing was written during the freeze, the holding copy simply resumes tracking and shows the time that elapsed meanwhile.

Top module: `bcd_calendar_clock`

## Requirements
- R1: After reset, reads show time 00:00:00, day of week 01, day of month 01, month 01, year 00, century 20, and control register 0x80 (transfer enabled).
- R2: Field offsets are 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 day of month, 5 month, 6 year and 7 century. The control register sits at offset 0xF with transfer enable in bit 7. Written values are masked to the field width: 7 bits for seconds and minutes, 6 bits for hours and day of month, 5 bits for month, 3 bits for day of week, 8 bits for year and century. Offsets 0x8 to 0xE and unused control bits read as zero.
- R3: Each seconds pulse adds one to the seconds field. Seconds wrap 59 to 00 and carry into minutes, minutes wrap 59 to 00 and carry into hours, and hours wrap 23 to 00 and mark a day change.
- R4: At a day change, day of month wraps to 01 after 30 in months 04, 06, 09 and 11, after 31 in the other months, and in month 02 after 29 when the year is a multiple of four and after 28 otherwise. Every wrap advances the month.
- R5: Month wraps 12 to 01 and advances the year. Year wraps 99 to 00 and advances the century, which wraps 99 to 00.
- R6: Day of week runs 01 to 07 and steps once per day change, with 07 followed by 01.
- R7: While transfer is enabled, the holding copy loads the running counter on every clock. A read therefore shows a counter change one clock after that change.
- R8: While transfer is disabled, the holding copy changes only by host writes, and seconds pulses still advance the running counter. Re-enabling transfer with no write made during the freeze shows the advanced time one clock later.
- R9: Time-field writes made while transfer is disabled are readable on the next clock. Setting transfer enable again loads all of them into the running counter on that same clock. A seconds pulse in that clock is discarded.
- R10: A time-field write made while transfer is enabled loads that running-counter field directly and is readable two clocks after the write clock.
- R11: Month bits 7:5 are plain storage. Every write to offset 5 updates them at once, whatever the transfer-enable bit is. They read back unchanged, and month counting never alters them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-clock pulse per elapsed second |
| bus_wr | input | 1 | Register write strobe, sampled on the rising clock edge |
| bus_addr | input | ADDR_W | Register offset for reads and writes |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |

## Verification
The results fall due at different clocks. A frozen-mode field write is readable one clock after its write clock. A direct write or a seconds pulse reaches the running counter at its own clock edge and the visible copy one clock later, so it is readable two clocks after it. A commit loads the counter at the control-write edge, and tracking resumes one clock after that. The bench model updates its own running counter and holding copy on each rising edge with these same latencies, and every clock, one nanosecond before the next rising edge, it compares the byte at the current bus address with the model. The directed checks sample in the same window. One directed check reads immediately after a direct write to confirm the one-clock lag of the visible copy.

// File: rtl/cal_pkg.sv
`timescale 1ns/1ps
package cal_pkg;
  localparam int NFLD   = 8;
  localparam int I_SEC  = 0;
  localparam int I_MIN  = 1;
  localparam int I_HOUR = 2;
  localparam int I_WDAY = 3;
  localparam int I_MDAY = 4;
  localparam int I_MON  = 5;
  localparam int I_YEAR = 6;
  localparam int I_CENT = 7;

  typedef logic [7:0] bcd8_t;
  typedef logic [NFLD-1:0][7:0] tset_t;

  // one BCD increment, no range limit
  function automatic bcd8_t bcd_step(bcd8_t v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic bcd8_t fld_mask(int i);
    case (i)
      I_SEC, I_MIN:   return 8'h7F;
      I_HOUR, I_MDAY: return 8'h3F;
      I_WDAY:         return 8'h07;
      I_MON:          return 8'h1F;
      default:        return 8'hFF;
    endcase
  endfunction

  function automatic bcd8_t fld_reset(int i);
    case (i)
      I_WDAY, I_MDAY, I_MON: return 8'h01;
      I_CENT:                return 8'h20;
      default:               return 8'h00;
    endcase
  endfunction

  function automatic bcd8_t fld_floor(int i);
    case (i)
      I_WDAY, I_MDAY, I_MON: return 8'h01;
      default:               return 8'h00;
    endcase
  endfunction

  function automatic bcd8_t fld_ceiling(int i);
    case (i)
      I_SEC, I_MIN: return 8'h59;
      I_HOUR:       return 8'h23;
      I_WDAY:       return 8'h07;
      I_MDAY:       return 8'h31;
      I_MON:        return 8'h12;
      default:      return 8'h99;
    endcase
  endfunction

  // value = 10*tens + ones; divisible by 4 iff (2*tens + ones) mod 4 == 0
  function automatic logic leap_bcd(bcd8_t y);
    logic [1:0] s;
    s = y[1:0] + {y[4], 1'b0};
    return (s == 2'd0);
  endfunction

  function automatic bcd8_t days_in_month(bcd8_t mon, bcd8_t yr);
    case (mon)
      8'h02:                      return leap_bcd(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/cal_bcd_ctr.sv
`timescale 1ns/1ps
module cal_bcd_ctr import cal_pkg::*; #(
  parameter bcd8_t RST_VAL = 8'h00,
  parameter bcd8_t FLOOR   = 8'h00,
  parameter bcd8_t MASK    = 8'hFF
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  step_i,
  input  logic  load_i,
  input  bcd8_t load_val_i,
  input  bcd8_t ceil_i,
  output bcd8_t val_o
);
  bcd8_t q, nxt;
  logic  at_top;

  assign at_top = (q == ceil_i);

  always_comb begin
    nxt = q;
    if (load_i)      nxt = load_val_i & MASK;
    else if (step_i) nxt = at_top ? FLOOR : (bcd_step(q) & MASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST_VAL;
    else        q <= nxt;
  end

  assign val_o = q;
endmodule

// File: rtl/cal_time_core.sv
`timescale 1ns/1ps
module cal_time_core import cal_pkg::*; (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sec_pulse_i,
  input  logic [NFLD-1:0] load_i,
  input  tset_t           load_val_i,
  output tset_t           now_o,
  output bcd8_t           mlen_o,
  output logic            sec_wrap_o,
  output logic            wday_wrap_o,
  output logic            mday_wrap_o
);
  logic [NFLD-1:0] step;
  logic [NFLD-2:0] at_top;
  logic sec_wrap, min_wrap, day_wrap, wday_wrap, mday_wrap, mon_wrap, year_wrap;

  assign mlen_o = days_in_month(now_o[I_MON], now_o[I_YEAR]);

  for (genvar i = 0; i < NFLD; i++) begin : g_fld
    bcd8_t ceil_v;
    if (i == I_MDAY) begin : g_dyn
      assign ceil_v = mlen_o;
    end else begin : g_fix
      assign ceil_v = fld_ceiling(i);
    end
    cal_bcd_ctr #(
      .RST_VAL(fld_reset(i)),
      .FLOOR  (fld_floor(i)),
      .MASK   (fld_mask(i))
    ) u_ctr (
      .clk       (clk),
      .rst_n     (rst_n),
      .step_i    (step[i]),
      .load_i    (load_i[i]),
      .load_val_i(load_val_i[i]),
      .ceil_i    (ceil_v),
      .val_o     (now_o[i])
    );
    if (i < NFLD-1) begin : g_top
      assign at_top[i] = (now_o[i] == ceil_v);
    end
  end

  // carry chain; a field being loaded passes no carry on
  assign sec_wrap  = sec_pulse_i & ~load_i[I_SEC]  & at_top[I_SEC];
  assign min_wrap  = sec_wrap    & ~load_i[I_MIN]  & at_top[I_MIN];
  assign day_wrap  = min_wrap    & ~load_i[I_HOUR] & at_top[I_HOUR];
  assign wday_wrap = day_wrap    & ~load_i[I_WDAY] & at_top[I_WDAY];
  assign mday_wrap = day_wrap    & ~load_i[I_MDAY] & at_top[I_MDAY];
  assign mon_wrap  = mday_wrap   & ~load_i[I_MON]  & at_top[I_MON];
  assign year_wrap = mon_wrap    & ~load_i[I_YEAR] & at_top[I_YEAR];

  assign step = {year_wrap, mon_wrap, mday_wrap, day_wrap,
                 day_wrap, min_wrap, sec_wrap, sec_pulse_i};

  assign sec_wrap_o  = sec_wrap;
  assign wday_wrap_o = wday_wrap;
  assign mday_wrap_o = mday_wrap;
endmodule

// File: rtl/cal_host_regs.sv
`timescale 1ns/1ps
module cal_host_regs import cal_pkg::*; #(
  parameter int                ADDR_W    = 4,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  bcd8_t             wdata_i,
  output bcd8_t             rdata_o,
  input  tset_t             now_i,
  output logic [NFLD-1:0]   load_o,
  output tset_t             load_val_o,
  output tset_t             shadow_o,
  output logic              xfer_en_o,
  output logic              commit_o,
  output logic              dirty_o
);
  localparam int HI_W = 8 - 5;

  tset_t           shadow_q;
  logic            xfer_en_q, dirty_q;
  logic [HI_W-1:0] mon_hi_q;
  logic            fld_sel, fld_wr, ctrl_wr, commit;
  logic [2:0]      fld_idx;

  assign fld_sel = (addr_i < ADDR_W'(NFLD));
  assign fld_idx = addr_i[2:0];
  assign fld_wr  = wr_i & fld_sel;
  assign ctrl_wr = wr_i & (addr_i == CTRL_ADDR);
  assign commit  = ctrl_wr & wdata_i[7] & ~xfer_en_q & dirty_q;

  for (genvar i = 0; i < NFLD; i++) begin : g_hold
    logic hit;
    assign hit           = fld_wr & (fld_idx == 3'(i));
    assign load_o[i]     = commit | (hit & xfer_en_q);
    assign load_val_o[i] = commit ? shadow_q[i] : wdata_i;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  shadow_q[i] <= fld_reset(i);
      else if (hit && !xfer_en_q)  shadow_q[i] <= wdata_i & fld_mask(i);
      else if (xfer_en_q)          shadow_q[i] <= now_i[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xfer_en_q <= 1'b1;
      dirty_q   <= 1'b0;
      mon_hi_q  <= '0;
    end else begin
      if (ctrl_wr) xfer_en_q <= wdata_i[7];
      if (ctrl_wr && wdata_i[7])     dirty_q <= 1'b0;
      else if (fld_wr && !xfer_en_q) dirty_q <= 1'b1;
      if (fld_wr && fld_idx == 3'(I_MON)) mon_hi_q <= wdata_i[7:8-HI_W];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (fld_sel) begin
      rdata_o = shadow_q[fld_idx];
      if (fld_idx == 3'(I_MON)) rdata_o[7:8-HI_W] = mon_hi_q;
    end else if (addr_i == CTRL_ADDR) begin
      rdata_o[7] = xfer_en_q;
    end
  end

  assign shadow_o  = shadow_q;
  assign xfer_en_o = xfer_en_q;
  assign commit_o  = commit;
  assign dirty_o   = dirty_q;
endmodule

// File: rtl/bcd_calendar_clock.sv
`timescale 1ns/1ps
module bcd_calendar_clock import cal_pkg::*; #(
  parameter int                ADDR_W    = 4,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata
);
  tset_t           core_now, shadow, load_val;
  logic [NFLD-1:0] load;
  bcd8_t           mlen;
  logic            xfer_en, commit, dirty;
  logic            sec_wrap, wday_wrap, mday_wrap;

  cal_host_regs #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_i      (bus_wr),
    .addr_i    (bus_addr),
    .wdata_i   (bus_wdata),
    .rdata_o   (bus_rdata),
    .now_i     (core_now),
    .load_o    (load),
    .load_val_o(load_val),
    .shadow_o  (shadow),
    .xfer_en_o (xfer_en),
    .commit_o  (commit),
    .dirty_o   (dirty)
  );

  cal_time_core u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .sec_pulse_i(sec_tick),
    .load_i     (load),
    .load_val_i (load_val),
    .now_o      (core_now),
    .mlen_o     (mlen),
    .sec_wrap_o (sec_wrap),
    .wday_wrap_o(wday_wrap),
    .mday_wrap_o(mday_wrap)
  );
endmodule

// File: rtl/cal_clock_chk.sv
`timescale 1ns/1ps
module cal_clock_chk import cal_pkg::*; (
  input logic            clk,
  input logic            rst_n,
  input logic            sec_tick,
  input logic            bus_wr,
  input logic            xfer_en,
  input logic            commit,
  input logic            dirty,
  input logic            sec_wrap,
  input logic            wday_wrap,
  input logic            mday_wrap,
  input bcd8_t           mlen,
  input logic [NFLD-1:0] load,
  input tset_t           core_now,
  input tset_t           shadow
);
  // R7
  follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_en |=> (shadow == $past(core_now)));

  // R8
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_en && !bus_wr) |=> $stable(shadow));

  // R9
  commit_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (core_now == $past(shadow)));

  // R9
  commit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !dirty);

  // R3
  sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_wrap |-> (core_now[I_SEC] == 8'h59));

  // R3
  tick_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && load == '0) |=> (core_now[I_SEC] != $past(core_now[I_SEC])));

  // R4
  mday_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mday_wrap |-> (core_now[I_MDAY] == mlen));

  // R4
  mday_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mday_wrap |=> (core_now[I_MDAY] == 8'h01));

  // R6
  wday_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wday_wrap |=> (core_now[I_WDAY] == 8'h01));
endmodule

bind bcd_calendar_clock cal_clock_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sec_tick (sec_tick),
  .bus_wr   (bus_wr),
  .xfer_en  (xfer_en),
  .commit   (commit),
  .dirty    (dirty),
  .sec_wrap (sec_wrap),
  .wday_wrap(wday_wrap),
  .mday_wrap(mday_wrap),
  .mlen     (mlen),
  .load     (load),
  .core_now (core_now),
  .shadow   (shadow)
);

// File: tb/bcd_calendar_clock_tb_top.sv
`timescale 1ns/1ps
module bcd_calendar_clock_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sec_tick = 1'b0;
  logic       bus_wr = 1'b0;
  logic [3:0] bus_addr = 4'h0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  run_chk = 1'b0;
  bit  finished = 1'b0;

  always #4 clk = ~clk;

  bcd_calendar_clock dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .sec_tick (sec_tick),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata)
  );

  // ---------------- behavioural reference (binary integers) ----------------
  int mc[8];
  int ms[8];
  int nc[8];
  bit m_te;
  bit m_dirty;
  logic [2:0] m_mhi;

  function automatic logic [7:0] wmask(int a);
    case (a)
      0, 1:    return 8'h7F;
      2, 4:    return 8'h3F;
      3:       return 8'h07;
      5:       return 8'h1F;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic int b2i(logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic logic [7:0] i2b(int v);
    return 8'(((v / 10) % 10) * 16 + (v % 10));
  endfunction

  function automatic int mdays(int mo, int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic adv_nc();
    nc[0]++;
    if (nc[0] < 60) return;
    nc[0] = 0; nc[1]++;
    if (nc[1] < 60) return;
    nc[1] = 0; nc[2]++;
    if (nc[2] < 24) return;
    nc[2] = 0;
    nc[3] = (nc[3] == 7) ? 1 : nc[3] + 1;
    if (nc[4] < mdays(nc[5], nc[6])) begin nc[4]++; return; end
    nc[4] = 1; nc[5]++;
    if (nc[5] <= 12) return;
    nc[5] = 1; nc[6]++;
    if (nc[6] <= 99) return;
    nc[6] = 0; nc[7] = (nc[7] + 1) % 100;
  endtask

  function automatic logic [7:0] model_read(logic [3:0] a);
    logic [7:0] v;
    v = 8'h00;
    if (a < 4'd8) begin
      v = i2b(ms[a]);
      if (a == 4'd5) v[7:5] = m_mhi;
    end else if (a == 4'hF) begin
      v[7] = m_te;
    end
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mc = '{0, 0, 0, 1, 1, 1, 0, 20};
      ms = mc;
      m_te = 1'b1; m_dirty = 1'b0; m_mhi = 3'd0;
    end else begin
      bit cm, dw, fw;
      int a;
      a  = int'(bus_addr);
      fw = bus_wr && (a < 8);
      cm = bus_wr && (a == 15) && bus_wdata[7] && !m_te && m_dirty;
      dw = fw && m_te;
      nc = mc;
      if (cm)            nc = ms;
      else if (dw)       nc[a] = b2i(bus_wdata & wmask(a));
      else if (sec_tick) adv_nc();
      if (m_te) ms = mc;
      else if (fw) begin
        ms[a] = b2i(bus_wdata & wmask(a));
        m_dirty = 1'b1;
      end
      if (bus_wr && a == 5) m_mhi = bus_wdata[7:5];
      if (bus_wr && a == 15) begin
        m_te = bus_wdata[7];
        if (bus_wdata[7]) m_dirty = 1'b0;
      end
      mc = nc;
    end
  end

  // per-cycle comparison, 1 ns before the next rising edge
  always @(negedge clk) begin
    #3;
    if (run_chk) begin
      n_chk++;
      if (bus_rdata !== model_read(bus_addr)) begin
        n_fail++;
        $display("FAIL R7 per-cycle compare addr %0h actual %02h expected %02h",
                 bus_addr, bus_rdata, model_read(bus_addr));
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [3:0] a, input logic [7:0] d, input logic tk = 1'b0);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; sec_tick = tk;
    @(negedge clk);
    bus_wr = 1'b0; sec_tick = 1'b0;
  endtask

  task automatic tick_n(input int n);
    repeat (n) begin
      @(negedge clk); sec_tick = 1'b1;
      @(negedge clk); sec_tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic judge(input string tag, input logic [3:0] a, input logic [7:0] exp);
    n_chk++;
    if (bus_rdata !== exp) begin
      n_fail++;
      $display("FAIL %s addr %0h actual %02h expected %02h", tag, a, bus_rdata, exp);
    end
  endtask

  task automatic expect_reg(input string tag, input logic [3:0] a, input logic [7:0] exp);
    @(negedge clk);
    bus_addr = a;
    #3;
    judge(tag, a, exp);
  endtask

  task automatic expect_now(input string tag, input logic [3:0] a, input logic [7:0] exp);
    bus_addr = a;
    #3;
    judge(tag, a, exp);
  endtask

  task automatic set_time(input logic [7:0] s, mi, h, wd, md, mo, y, c);
    wr(4'hF, 8'h00);
    wr(4'h0, s);  wr(4'h1, mi); wr(4'h2, h);  wr(4'h3, wd);
    wr(4'h4, md); wr(4'h5, mo); wr(4'h6, y);  wr(4'h7, c);
    wr(4'hF, 8'h80);
    repeat (2) @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(8 * 100000);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired before the sequence ended");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  // ---------------- sequence ----------------
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    run_chk = 1'b1;

    // R1 reset state
    expect_reg("R1 sec",   4'h0, 8'h00);
    expect_reg("R1 min",   4'h1, 8'h00);
    expect_reg("R1 hour",  4'h2, 8'h00);
    expect_reg("R1 wday",  4'h3, 8'h01);
    expect_reg("R1 mday",  4'h4, 8'h01);
    expect_reg("R1 month", 4'h5, 8'h01);
    expect_reg("R1 year",  4'h6, 8'h00);
    expect_reg("R1 cent",  4'h7, 8'h20);
    expect_reg("R1 ctrl",  4'hF, 8'h80);

    // R2 unused offsets and masking
    for (int a = 8; a < 15; a++) expect_reg("R2 unused offset", 4'(a), 8'h00);
    wr(4'h2, 8'hE3);
    expect_reg("R2 hour mask", 4'h2, 8'h23);
    wr(4'h3, 8'hF5);
    expect_reg("R2 wday mask", 4'h3, 8'h05);

    // R3 R6 R4 second-to-day rollover, non-leap February
    set_time(8'h58, 8'h59, 8'h23, 8'h07, 8'h28, 8'h02, 8'h03, 8'h20);
    tick_n(1);
    expect_reg("R3 sec step", 4'h0, 8'h59);
    tick_n(1);
    expect_reg("R3 sec wrap",  4'h0, 8'h00);
    expect_reg("R3 min wrap",  4'h1, 8'h00);
    expect_reg("R3 hour wrap", 4'h2, 8'h00);
    expect_reg("R6 wday 7->1", 4'h3, 8'h01);
    expect_reg("R4 feb28 end", 4'h4, 8'h01);
    expect_reg("R4 to march",  4'h5, 8'h03);

    // R4 leap February
    set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h04, 8'h20);
    tick_n(1);
    expect_reg("R4 leap day",  4'h4, 8'h29);
    expect_reg("R6 wday step", 4'h3, 8'h04);
    set_time(8'h59, 8'h59, 8'h23, 8'h04, 8'h29, 8'h02, 8'h04, 8'h20);
    tick_n(1);
    expect_reg("R4 leap end", 4'h4, 8'h01);
    expect_reg("R4 leap mon", 4'h5, 8'h03);

    // R4 R11 thirty-day month with stored high month bits
    set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'hE4, 8'h10, 8'h20);
    expect_reg("R11 hi bits read", 4'h5, 8'hE4);
    tick_n(1);
    expect_reg("R4 april end",   4'h4, 8'h01);
    expect_reg("R11 hi bits kept", 4'h5, 8'hE5);
    set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h05, 8'h10, 8'h20);
    tick_n(1);
    expect_reg("R4 may 31", 4'h4, 8'h31);

    // R5 year and century
    set_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99, 8'h20);
    tick_n(1);
    expect_reg("R5 month wrap", 4'h5, 8'h01);
    expect_reg("R5 year wrap",  4'h6, 8'h00);
    expect_reg("R5 century",    4'h7, 8'h21);
    expect_reg("R6 wday wrap",  4'h3, 8'h01);

    // R8 freeze while counting
    set_time(8'h10, 8'h20, 8'h10, 8'h01, 8'h15, 8'h06, 8'h22, 8'h20);
    wr(4'hF, 8'h00);
    expect_reg("R8 ctrl clear", 4'hF, 8'h00);
    tick_n(3);
    expect_reg("R8 frozen sec", 4'h0, 8'h10);
    wr(4'hF, 8'h80);
    expect_reg("R8 resumed sec", 4'h0, 8'h13);

    // R9 frozen write, commit with coincident tick
    wr(4'hF, 8'h00);
    wr(4'h1, 8'h15);
    expect_now("R9 shadow write", 4'h1, 8'h15);
    tick_n(2);
    expect_reg("R9 still frozen", 4'h0, 8'h13);
    wr(4'hF, 8'h80, 1'b1);
    repeat (2) @(negedge clk);
    expect_reg("R9 tick dropped", 4'h0, 8'h13);
    expect_reg("R9 min commit",   4'h1, 8'h15);
    tick_n(1);
    expect_reg("R3 after commit", 4'h0, 8'h14);

    // R10 R7 direct write and one-clock lag
    wr(4'h1, 8'h42);
    expect_now("R7 lag before follow", 4'h1, 8'h15);
    expect_reg("R10 direct write", 4'h1, 8'h42);
    wr(4'h5, 8'hA6);
    expect_reg("R11 write te=1", 4'h5, 8'hA6);

    repeat (4) @(negedge clk);
    run_chk = 1'b0;
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule